// File: doc/BRIEF.md
# Signed Integer Cube Root Unit

This unit takes a signed 24-bit two's complement operand and returns its integer cube root as a 9-bit two's complement value, truncated toward zero. A one-cycle start pulse, sampled while the unit is idle, captures the operand. The unit then works on the unsigned magnitude and decides the root one bit at a time, from the most significant bit down. In each step it sets a trial bit, cubes the trial value and keeps the bit only if that cube does not exceed the magnitude. When the search is over, the sign is put back and the result is written into an output register, together with a one-cycle completion pulse.

The search takes one cycle per root magnitude bit. A linear scan over all candidates would take about two hundred cycles. Here the full operation takes a fixed ten cycles from the accepting clock edge to the completion pulse. The result register keeps its value until the next result is loaded. A new request is therefore free to start while the previous answer is still being read.

Top module: `cube_root_unit`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, `done` is 0 and `root` is 0 after that edge. No storage element uses an asynchronous set or reset.
- R2: For a non-negative operand N, `root` is the largest integer r with r*r*r <= N (for example 4194303 gives 161 and 8388607 gives 203).
- R3: For a negative operand, `root` is the two's complement negation of the root of its magnitude, so the result is truncated toward zero (for example -4194303 gives -161, which is 9'b101011111).
- R4: The most negative operand, -8388608, gives -203. The magnitude of every result r satisfies r*r*r <= 2^23.
- R5: An operand of 0 gives 0. Operands from 1 to 7 give 1, and operands from -7 to -1 give -1. Operands 8 and -8 give 2 and -2.
- R6: When `start` is accepted at clock edge k, `done` is 1 for exactly one cycle, following edge k+9, and `root` holds the new result in that same cycle.
- R7: A `start` pulse that arrives while a computation is in progress is ignored. The running computation still finishes on time, with the result for the operand that was first captured.
- R8: `root` changes only in the cycle in which `done` is 1. A `start` accepted in the same cycle as `done` begins a new computation, and the previous result stays on `root` until that new computation completes.
- R9: A reset during a computation abandons it, and no `done` pulse follows for the abandoned operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; accepted only while idle |
| operand | input | 24 | Signed two's complement operand, captured on acceptance |
| done | output | 1 | One-cycle pulse when a new result is loaded |
| root | output | 9 | Signed two's complement cube root, truncated toward zero |

## Verification
Two events can fall in the same cycle: the completion pulse for one operand and the acceptance of the next request. The bench provokes this by raising `start` with a fresh operand in exactly the cycle in which `done` is seen high. It then checks three things. The new request must be accepted. The old root must remain on `root` throughout the second search. The second result must appear with its `done` pulse exactly nine edges after the accepting edge. A second overlap is also covered: a `start` raised in the middle of a search must be ignored, and the original result must still arrive on time.

// File: rtl/cbrt_pkg.sv
package cbrt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FIN    = 2'd2
  } cbrt_state_e;

endpackage

// File: rtl/cbrt_ctrl.sv
module cbrt_ctrl
  import cbrt_pkg::*;
#(
  parameter int MAG_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load,
  output logic             step,
  output logic             finish,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAG_W - 1);

  cbrt_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign load   = (state_q == ST_IDLE) && start;
  assign step   = (state_q == ST_SEARCH);
  assign finish = (state_q == ST_FIN);
  assign idx    = idx_q;
  assign idx_en = load || step;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SEARCH;
          idx_d   = LAST_IDX;
        end
      end
      ST_SEARCH: begin
        if (idx_q == '0) begin
          state_d = ST_FIN;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // bit index register with explicit enable
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  // R7: while a search runs, a start request must not restart the index
  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (rst)
    (step && idx != '0) |=> (idx != LAST_IDX));

endmodule

// File: rtl/cbrt_magnitude.sv
module cbrt_magnitude #(
  parameter int OPER_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [OPER_W-1:0] operand,
  output logic [OPER_W-1:0] mag,
  output logic              neg
);

  logic [OPER_W-1:0] mag_d, mag_q;
  logic              neg_d, neg_q;

  // unsigned magnitude; the most negative operand maps to 2^(OPER_W-1)
  always_comb begin
    neg_d = operand[OPER_W-1];
    mag_d = neg_d ? (~operand + 1'b1) : operand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else if (load) begin
      mag_q <= mag_d;
      neg_q <= neg_d;
    end
  end

  assign mag = mag_q;
  assign neg = neg_q;

endmodule

// File: rtl/cbrt_search.sv
module cbrt_search #(
  parameter int MAG_W  = 8,
  parameter int OPER_W = 24,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OPER_W-1:0] mag,
  output logic [MAG_W-1:0]  trial
);

  localparam int SQ_W   = 2 * MAG_W;
  localparam int CUBE_W = 3 * MAG_W;
  localparam int CMP_W  = (CUBE_W > OPER_W) ? CUBE_W : OPER_W;

  logic [MAG_W-1:0]  trial_q, trial_d, cand, bit_sel;
  logic [SQ_W-1:0]   cand_sq;
  logic [CUBE_W-1:0] cand_cube;
  logic [CMP_W-1:0]  cube_ext, mag_ext;
  logic              keep;

  always_comb begin
    bit_sel   = {{(MAG_W-1){1'b0}}, 1'b1} << idx;
    cand      = trial_q | bit_sel;
    cand_sq   = {{MAG_W{1'b0}}, cand} * {{MAG_W{1'b0}}, cand};
    cand_cube = {{MAG_W{1'b0}}, cand_sq} * {{SQ_W{1'b0}}, cand};
    cube_ext  = CMP_W'(cand_cube);
    mag_ext   = CMP_W'(mag);
    keep      = (cube_ext <= mag_ext);
  end

  always_comb begin
    trial_d = trial_q;
    if (load) begin
      trial_d = '0;
    end else if (step && keep) begin
      trial_d = cand;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q <= '0;
    end else if (load || step) begin
      trial_q <= trial_d;
    end
  end

  assign trial = trial_q;

  // R2: during a search the partial root never loses a bit it has kept
  assert_trial_monotone_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> ((trial & $past(trial)) == $past(trial)));

endmodule

// File: rtl/cbrt_sign.sv
module cbrt_sign #(
  parameter int MAG_W  = 8,
  parameter int ROOT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              finish,
  input  logic              neg,
  input  logic [MAG_W-1:0]  trial,
  output logic [ROOT_W-1:0] root,
  output logic              done
);

  logic [ROOT_W-1:0] ext, root_d, root_q;
  logic              done_q;

  always_comb begin
    ext    = ROOT_W'(trial);
    root_d = neg ? (~ext + 1'b1) : ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      root_q <= '0;
    end else if (finish) begin
      root_q <= root_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
    end
  end

  assign root = root_q;
  assign done = done_q;

  // R6: the completion pulse lasts a single cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the result only moves together with the completion pulse
  assert_root_held_R8: assert property (@(posedge clk) disable iff (rst)
    !done |=> (root == $past(root)) || done);

endmodule

// File: rtl/cube_root_unit.sv
module cube_root_unit #(
  parameter int OPER_W = 24,
  parameter int ROOT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OPER_W-1:0] operand,
  output logic              done,
  output logic [ROOT_W-1:0] root
);

  localparam int MAG_W   = ROOT_W - 1;
  localparam int IDX_W   = (MAG_W > 1) ? $clog2(MAG_W) : 1;
  localparam int LATENCY = MAG_W + 1;

  logic              load, step, finish, neg;
  logic [IDX_W-1:0]  idx;
  logic [OPER_W-1:0] mag;
  logic [MAG_W-1:0]  trial;

  cbrt_ctrl #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .finish(finish), .idx(idx)
  );

  cbrt_magnitude #(.OPER_W(OPER_W)) u_mag (
    .clk(clk), .rst(rst), .load(load), .operand(operand),
    .mag(mag), .neg(neg)
  );

  cbrt_search #(.MAG_W(MAG_W), .OPER_W(OPER_W), .IDX_W(IDX_W)) u_search (
    .clk(clk), .rst(rst), .load(load), .step(step), .idx(idx),
    .mag(mag), .trial(trial)
  );

  cbrt_sign #(.MAG_W(MAG_W), .ROOT_W(ROOT_W)) u_sign (
    .clk(clk), .rst(rst), .finish(finish), .neg(neg), .trial(trial),
    .root(root), .done(done)
  );

  // latency window counter for the checks below
  logic [7:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
    end else if (load) begin
      lat_q <= '0;
    end else if (lat_q != 8'hFF) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R6: completion arrives a fixed number of edges after acceptance
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == 8'(LATENCY)));

  // R4: no result magnitude may cube beyond the largest operand magnitude
  logic signed [ROOT_W-1:0] root_s;
  longint                   root_abs;
  always_comb begin
    root_s   = $signed(root);
    root_abs = (root_s < 0) ? -longint'(root_s) : longint'(root_s);
  end
  assert_root_bound_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (root_abs * root_abs * root_abs <= (longint'(1) <<< (OPER_W - 1))));

endmodule

// File: tb/test_cube_root_unit.sv
module test_cube_root_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [23:0] operand;
  logic        done;
  logic [8:0]  root;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  cube_root_unit i_cube_root_unit (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .done(done), .root(root)
  );

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int ref_root(input int v);
    int m = (v < 0) ? -v : v;
    int r = 0;
    while ((r + 1) * (r + 1) * (r + 1) <= m) r++;
    return (v < 0) ? -r : r;
  endfunction

  function automatic int as_int(input logic [8:0] x);
    return int'($signed(x));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive start for one cycle and wait; returns cycle count (negedges) to done.
  task automatic issue_and_wait(input int v, output int when);
    operand = 24'(v);
    start   = 1'b1;
    when    = -1;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done && when < 0) when = c;
      if (when >= 0) break;
    end
  endtask

  // R2 R3 R4 R5 R6: one full operation with value, latency and pulse width
  task automatic run_op(input int v, input string req);
    int when;
    issue_and_wait(v, when);
    check(when == 10, "R6 latency", when, 10);
    check(as_int(root) == ref_root(v), req, as_int(root), ref_root(v));
    @(negedge clk);
    check(done == 1'b0, "R6 single pulse", int'(done), 0);
  endtask

  task automatic test_reset_state;
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(root == 9'd0, "R1 root after reset", as_int(root), 0);
  endtask

  task automatic test_positive;
    run_op(4194303, "R2 4194303");
    check(root == 9'b010100001, "R2 bit pattern", as_int(root), 161);
    run_op(8388607, "R2 max positive");
    run_op(1000, "R2 exact cube");
    run_op(999, "R2 below cube");
    run_op(1001, "R2 above cube");
    for (int k = 20; k <= 203; k += 61) begin
      run_op(k * k * k, "R2 cube sweep");
      run_op(k * k * k - 1, "R2 cube-1 sweep");
    end
  endtask

  task automatic test_negative;
    run_op(-4194303, "R3 -4194303");
    check(root == 9'b101011111, "R3 bit pattern", as_int(root), -161);
    run_op(-1000, "R3 exact cube");
    run_op(-999, "R3 truncate toward zero");
    run_op(-8388607, "R3 large negative");
  endtask

  task automatic test_extreme;
    run_op(-8388608, "R4 most negative");
    check(as_int(root) == -203, "R4 -8388608 gives -203", as_int(root), -203);
  endtask

  task automatic test_small;
    run_op(0, "R5 zero");
    run_op(1, "R5 one");
    run_op(7, "R5 seven");
    run_op(-1, "R5 minus one");
    run_op(-7, "R5 minus seven");
    run_op(8, "R5 eight");
    run_op(-8, "R5 minus eight");
  endtask

  task automatic test_busy_start;
    int when = -1;
    operand = 24'(27);
    start   = 1'b1;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (c == 4) begin
        start   = 1'b1;
        operand = 24'(-125);
      end else begin
        start   = 1'b0;
        operand = 24'(27);
      end
      if (done && when < 0) when = c;
      if (when >= 0) break;
    end
    start = 1'b0;
    check(when == 10, "R7 latency unchanged", when, 10);
    check(as_int(root) == 3, "R7 first operand kept", as_int(root), 3);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (done) when = -2;
    end
    check(when != -2, "R7 no extra done", when, 10);
  endtask

  task automatic test_back_to_back;
    int when;
    int held = 1;
    run_op(64, "R8 first result");
    // now issue while done is high: finish the next, then overlap
    operand = 24'(343);
    start   = 1'b1;
    when    = -1;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (done && when < 0) begin
        when    = c;
        start   = 1'b1;
        operand = 24'(-216);
      end else begin
        start = 1'b0;
      end
      if (when >= 0) break;
    end
    check(as_int(root) == 7, "R8 result before overlap", as_int(root), 7);
    when = -1;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done && when < 0) when = c;
      if (when < 0 && as_int(root) != 7) held = 0;
      if (when >= 0) break;
    end
    check(held == 1, "R8 old root held", held, 1);
    check(when == 10, "R8 overlapped start accepted", when, 10);
    check(as_int(root) == -6, "R8 new result", as_int(root), -6);
  endtask

  task automatic test_reset_abort;
    int seen = 0;
    operand = 24'(1000000);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen == 0, "R9 no done after abort", seen, 0);
    check(root == 9'd0, "R9 root cleared", as_int(root), 0);
    run_op(125, "R9 works after abort");
  endtask

  initial begin
    rst     = 1'b1;
    start   = 1'b0;
    operand = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset_state();
    test_positive();
    test_negative();
    test_extreme();
    test_small();
    test_busy_start();
    test_back_to_back();
    test_reset_abort();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule